// File: doc/BRIEF.md
# Transmit Descriptor Hold Controller

This block is the transmit side of one channel in a descriptor-driven DMA engine. It walks a linked chain of transmit descriptors in system memory. For each descriptor it reads a flags word, a data pointer and a next pointer. It then copies the data section, one word at a time, into the transmit buffer, but only as far as the buffer has asked for data. A descriptor marked hold stops the walk. After its data has gone out, the flags word is read again. If the hold mark has been cleared, the walk goes on to the next descriptor. If it is still set, the channel parks and waits for the host.

While the channel is parked, buffer requests are not served. They are added to a saturating open-request counter instead. The host sends a hold-reset command each time it clears a hold mark. That command arms the parked channel. The next buffer request, or any stored open requests, then makes the channel poll the flags word again. A mode input selects framed or transparent operation. In framed mode, a hold descriptor that does not close a frame ends with an abort mark on the last word it delivers, followed by an interrupt. In transparent mode, every hold descriptor raises the interrupt and no abort mark is ever sent.

Top module: `txHoldCtrl`

## Requirements
- R1: After reset, and until a start pulse arrives, the block issues no memory read, no buffer write and no interrupt.
- R2: A descriptor at word address D is read in the order D, D+1, D+2. Word D holds the flags: bit 31 is hold, bit 30 is frame end, bits 15:0 are the length in words. Word D+1 is the data pointer and word D+2 is the next-descriptor pointer. The data words are delivered in address order, and the last word of each section carries `bufWrLast`.
- R3: In framed mode (`modeTransparent`=0), a descriptor with hold set and frame end clear still delivers its whole section. Its last word carries `bufWrAbort`. An interrupt with code 4'hA follows exactly two cycles after that last word.
- R4: In transparent mode, every descriptor with hold set raises one interrupt with code 4'hA, whatever its frame-end bit. `bufWrAbort` is never set in this mode.
- R5: A descriptor with hold clear raises no interrupt. In framed mode, a descriptor with both hold and frame end set raises no interrupt.
- R6: After the section of a hold descriptor, its flags word is read again. If hold is clear by then, the walk moves to the next descriptor with no host action.
- R7: If hold is still set on that second read, the channel is suspended. It makes no memory reads and no buffer writes, even when the buffer makes requests.
- R8: Requested data units (`bufReqCnt` per `bufReq` pulse) build up in an open-request counter that saturates at 2^CNT_W-1. After a resume, the stored units are served without any new request.
- R9: A hold-reset command to a suspended channel arms it. A later buffer request, or a nonzero open count, makes it read the flags word again, and it resumes with the next descriptor if hold is clear.
- R10: If that poll still finds hold set, the channel stays suspended and delivers no data.
- R11: A hold-reset command while the channel is not suspended has no effect on the walk.
- R12: Each delivered word uses one requested unit. With no units left, no word is delivered.
- R13: The interrupt is a one-cycle pulse that carries the code and the channel number `CHAN_ID`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeTransparent | input | 1 | 1 = transparent mode, 0 = framed mode |
| start | input | 1 | Pulse that begins the walk at `startAddr` |
| startAddr | input | ADDR_W | Address of the first descriptor |
| holdResetCmd | input | 1 | Host hold-reset command pulse |
| memReqValid | output | 1 | Memory read request valid |
| memReqReady | input | 1 | Memory accepts the request |
| memReqAddr | output | ADDR_W | Memory read word address |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | DATA_W | Read data |
| bufReq | input | 1 | Buffer data request pulse |
| bufReqCnt | input | REQ_W | Number of words requested |
| bufWrValid | output | 1 | Data word to the buffer valid |
| bufWrData | output | DATA_W | Data word |
| bufWrLast | output | 1 | Last word of a data section |
| bufWrAbort | output | 1 | Abort mark for the framing side |
| irqValid | output | 1 | Interrupt vector pulse |
| irqCode | output | 4 | Interrupt code |
| irqChan | output | CHAN_W | Channel number |

## Verification
A data word shows up on the buffer port in the same cycle that its memory response arrives. The bench's memory model returns data two cycles after it accepts a request. The hold interrupt comes exactly two cycles after the last word of its section, and the bench compares the cycle numbers it records for the two. Suspension and saturation are checked at the ports after settling windows long enough for any pending walk to finish: no reads or writes during the window, and exactly the saturated number of words after the resume. Every event is sampled two nanoseconds after the falling edge, once the memory model and the stimulus tasks have settled.

// File: rtl/txhPkg.sv
package txhPkg;
  localparam int HOLD_BIT = 31;
  localparam int FE_BIT   = 30;
  localparam logic [3:0] IRQ_HOLD_ABORT = 4'hA;

  typedef enum logic [1:0] {SEL_FLAGS, SEL_DPTR, SEL_NEXT, SEL_DATA} addrSel_e;

  typedef enum logic [2:0] {
    S_IDLE, S_FREQ, S_FWAIT, S_DCHK, S_DREQ, S_DWAIT, S_EVAL, S_SUSP
  } state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     loadStart;
    logic     latchFlags;
    logic     latchDptr;
    logic     latchNext;
    logic     advance;
    logic     beginData;
    logic     wordDone;
    addrSel_e addrSel;
  } strobe_t;
endpackage

// File: rtl/txhDatapath.sv
module txhDatapath import txhPkg::*; #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 16,
  parameter int CNT_W  = 6,
  parameter int REQ_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              rspHoldIn,
  input  logic              rspFeIn,
  input  logic [LEN_W-1:0]  rspLen,
  input  logic [ADDR_W-1:0] rspPtr,
  input  logic              bufReq,
  input  logic [REQ_W-1:0]  bufReqCnt,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic              descHold,
  output logic              descFe,
  output logic              remZero,
  output logic              remOne,
  output logic              openReqNz
);
  localparam int SUM_W = CNT_W + 2;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [ADDR_W-1:0] descPtr, dataPtr, nextPtr, offset;
  logic [LEN_W-1:0]  lenReg, remLen;
  logic [CNT_W-1:0]  openReq, openReqNext;
  logic [SUM_W-1:0]  sumNext;

  always_comb begin
    unique case (strb.addrSel)
      SEL_FLAGS: memReqAddr = descPtr;
      SEL_DPTR:  memReqAddr = descPtr + ADDR_W'(1);
      SEL_NEXT:  memReqAddr = descPtr + ADDR_W'(2);
      default:   memReqAddr = dataPtr + offset;
    endcase
  end

  // saturating open-request counter
  always_comb begin
    sumNext = SUM_W'(openReq) + (bufReq ? SUM_W'(bufReqCnt) : '0) - SUM_W'(strb.wordDone);
    openReqNext = (sumNext > SUM_W'(CNT_MAX)) ? CNT_MAX : sumNext[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      descPtr  <= '0;
      dataPtr  <= '0;
      nextPtr  <= '0;
      offset   <= '0;
      lenReg   <= '0;
      remLen   <= '0;
      descHold <= 1'b0;
      descFe   <= 1'b0;
      openReq  <= '0;
    end else begin
      if (strb.loadStart)    descPtr <= startAddr;
      else if (strb.advance) descPtr <= nextPtr;
      if (strb.latchFlags) begin
        descHold <= rspHoldIn;
        descFe   <= rspFeIn;
        lenReg   <= rspLen;
      end
      if (strb.latchDptr) dataPtr <= rspPtr;
      if (strb.latchNext) nextPtr <= rspPtr;
      if (strb.beginData) begin
        remLen <= lenReg;
        offset <= '0;
      end else if (strb.wordDone) begin
        remLen <= remLen - LEN_W'(1);
        offset <= offset + ADDR_W'(1);
      end
      openReq <= openReqNext;
    end
  end

  assign remZero   = (remLen == '0);
  assign remOne    = (remLen == LEN_W'(1));
  assign openReqNz = (openReq != '0);

  // R8: a full counter stays full until a word is served
  p_sat_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (openReq == CNT_MAX && !strb.wordDone) |=> (openReq == CNT_MAX));

  // R12: each served word consumes exactly one unit
  p_word_use_r12: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wordDone && !bufReq) |=> (openReq == $past(openReq) - CNT_W'(1)));
endmodule

// File: rtl/txhControl.sv
module txhControl import txhPkg::*; (
  input  logic       clk,
  input  logic       rstN,
  input  logic       modeTransparent,
  input  logic       start,
  input  logic       holdResetCmd,
  input  logic       bufReq,
  input  logic       memReqReady,
  input  logic       memRspValid,
  input  logic       rspHold,
  input  logic       descHold,
  input  logic       descFe,
  input  logic       remZero,
  input  logic       remOne,
  input  logic       openReqNz,
  output strobe_t    strb,
  output logic       memReqValid,
  output logic       bufWrValid,
  output logic       bufWrLast,
  output logic       bufWrAbort,
  output logic       irqValid,
  output logic [3:0] irqCode
);
  state_e     state, stateN;
  logic [1:0] idx, idxN;
  logic       check, checkN;
  logic       armed, armedN;

  always_comb begin
    strb        = '0;
    memReqValid = 1'b0;
    bufWrValid  = 1'b0;
    bufWrLast   = 1'b0;
    bufWrAbort  = 1'b0;
    irqValid    = 1'b0;
    stateN      = state;
    idxN        = idx;
    checkN      = check;
    armedN      = (state == S_SUSP) ? armed : 1'b0;
    unique case (state)
      S_IDLE: if (start) begin
        strb.loadStart = 1'b1;
        idxN = '0;
        checkN = 1'b0;
        stateN = S_FREQ;
      end
      S_FREQ: begin
        memReqValid = 1'b1;
        strb.addrSel = (idx == 2'd0) ? SEL_FLAGS : (idx == 2'd1) ? SEL_DPTR : SEL_NEXT;
        if (memReqReady) stateN = S_FWAIT;
      end
      S_FWAIT: if (memRspValid) begin
        strb.latchFlags = (idx == 2'd0);
        strb.latchDptr  = (idx == 2'd1);
        strb.latchNext  = (idx == 2'd2);
        if (check) begin
          if (rspHold) stateN = S_SUSP;
          else begin
            strb.advance = 1'b1;
            checkN = 1'b0;
            stateN = S_FREQ;
          end
        end else if (idx == 2'd2) begin
          strb.beginData = 1'b1;
          stateN = S_DCHK;
        end else begin
          idxN = idx + 2'd1;
          stateN = S_FREQ;
        end
      end
      S_DCHK: begin
        if (remZero)        stateN = S_EVAL;
        else if (openReqNz) stateN = S_DREQ;
      end
      S_DREQ: begin
        memReqValid  = 1'b1;
        strb.addrSel = SEL_DATA;
        if (memReqReady) stateN = S_DWAIT;
      end
      S_DWAIT: if (memRspValid) begin
        bufWrValid    = 1'b1;
        bufWrLast     = remOne;
        bufWrAbort    = remOne && descHold && !descFe && !modeTransparent;
        strb.wordDone = 1'b1;
        stateN        = S_DCHK;
      end
      S_EVAL: begin
        irqValid = modeTransparent ? descHold : (descHold && !descFe);
        idxN = '0;
        if (descHold) checkN = 1'b1;
        else strb.advance = 1'b1;
        stateN = S_FREQ;
      end
      S_SUSP: begin
        if (armed && (bufReq || openReqNz)) begin
          armedN = 1'b0;
          checkN = 1'b1;
          idxN   = '0;
          stateN = S_FREQ;
        end else if (holdResetCmd) armedN = 1'b1;
      end
      default: stateN = S_IDLE;
    endcase
  end

  assign irqCode = irqValid ? IRQ_HOLD_ABORT : 4'h0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      idx   <= '0;
      check <= 1'b0;
      armed <= 1'b0;
    end else begin
      state <= stateN;
      idx   <= idxN;
      check <= checkN;
      armed <= armedN;
    end
  end

  // R13: interrupt is a single-cycle pulse
  p_irq_pulse_r13: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |=> !irqValid);

  // R3: an abort mark is followed two cycles later by the hold interrupt
  p_abort_irq_r3: assert property (@(posedge clk) disable iff (!rstN)
    bufWrAbort |=> ##1 (irqValid && irqCode == IRQ_HOLD_ABORT));

  // R7: a suspended, unarmed channel stays put
  p_susp_stay_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_SUSP && !armed && !holdResetCmd) |=> (state == S_SUSP));
endmodule

// File: rtl/txHoldCtrl.sv
module txHoldCtrl import txhPkg::*; #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int LEN_W   = 16,
  parameter int CNT_W   = 6,
  parameter int REQ_W   = 4,
  parameter int CHAN_W  = 8,
  parameter int CHAN_ID = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeTransparent,
  input  logic              start,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              holdResetCmd,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memRspValid,
  input  logic [DATA_W-1:0] memRspData,
  input  logic              bufReq,
  input  logic [REQ_W-1:0]  bufReqCnt,
  output logic              bufWrValid,
  output logic [DATA_W-1:0] bufWrData,
  output logic              bufWrLast,
  output logic              bufWrAbort,
  output logic              irqValid,
  output logic [3:0]        irqCode,
  output logic [CHAN_W-1:0] irqChan
);
  strobe_t strb;
  logic descHold, descFe, remZero, remOne, openReqNz;

  txhControl u_ctl (
    .clk(clk), .rstN(rstN), .modeTransparent(modeTransparent), .start(start),
    .holdResetCmd(holdResetCmd), .bufReq(bufReq), .memReqReady(memReqReady),
    .memRspValid(memRspValid), .rspHold(memRspData[HOLD_BIT]),
    .descHold(descHold), .descFe(descFe), .remZero(remZero), .remOne(remOne),
    .openReqNz(openReqNz), .strb(strb), .memReqValid(memReqValid),
    .bufWrValid(bufWrValid), .bufWrLast(bufWrLast), .bufWrAbort(bufWrAbort),
    .irqValid(irqValid), .irqCode(irqCode)
  );

  txhDatapath #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W), .REQ_W(REQ_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .startAddr(startAddr),
    .rspHoldIn(memRspData[HOLD_BIT]), .rspFeIn(memRspData[FE_BIT]),
    .rspLen(memRspData[LEN_W-1:0]), .rspPtr(memRspData[ADDR_W-1:0]),
    .bufReq(bufReq), .bufReqCnt(bufReqCnt), .memReqAddr(memReqAddr),
    .descHold(descHold), .descFe(descFe), .remZero(remZero), .remOne(remOne),
    .openReqNz(openReqNz)
  );

  assign bufWrData = memRspData;
  assign irqChan   = CHAN_W'(CHAN_ID);

  // R2: a stalled read request keeps its address
  p_req_stable_r2: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqAddr)));
endmodule

// File: tb/sim_txHoldCtrl.sv
module sim_txHoldCtrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        modeTransparent = 1'b0;
  logic        start = 1'b0;
  logic [15:0] startAddr = '0;
  logic        holdResetCmd = 1'b0;
  logic        memReqValid;
  logic        memReqReady = 1'b1;
  logic [15:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;
  logic        bufReq = 1'b0;
  logic [3:0]  bufReqCnt = '0;
  logic        bufWrValid, bufWrLast, bufWrAbort, irqValid;
  logic [31:0] bufWrData;
  logic [3:0]  irqCode;
  logic [7:0]  irqChan;

  txHoldCtrl u0 (.*);

  always #5 clk = ~clk;

  logic [31:0] mem [0:255];
  logic        pV0 = 1'b0, pV1 = 1'b0;
  logic [31:0] pD0 = '0, pD1 = '0;
  int          mN = 0;
  logic [15:0] mAddr [0:4095];

  // memory with two cycles of latency and random request stalls
  always @(negedge clk) begin
    automatic bit rdy = ($urandom % 4) != 0;
    automatic bit acc = memReqValid && rdy;
    memReqReady <= rdy;
    memRspValid <= pV1;
    memRspData  <= pD1;
    pV1 <= pV0;
    pD1 <= pD0;
    pV0 <= acc;
    pD0 <= mem[memReqAddr[7:0]];
    if (acc) begin
      mAddr[mN] = memReqAddr;
      mN = mN + 1;
    end
  end

  int cyc = 0;
  always @(posedge clk) cyc = cyc + 1;

  int          wN = 0, iN = 0;
  logic [31:0] wData [0:4095];
  logic        wLast [0:4095];
  logic        wAbort [0:4095];
  int          wCyc [0:4095];
  logic [3:0]  iCode [0:255];
  logic [7:0]  iChan [0:255];
  int          iCyc [0:255];

  always begin
    @(negedge clk);
    #2;
    if (bufWrValid) begin
      wData[wN] = bufWrData; wLast[wN] = bufWrLast; wAbort[wN] = bufWrAbort; wCyc[wN] = cyc;
      wN = wN + 1;
    end
    if (irqValid) begin
      iCode[iN] = irqCode; iChan[iN] = irqChan; iCyc[iN] = cyc;
      iN = iN + 1;
    end
  end

  int nChecks = 0, nErr = 0;
  bit done = 1'b0;

  task automatic chkEq(input string tag, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int satCredit(input int total, input int maxv);
    return (total > maxv) ? maxv : total;
  endfunction

  function automatic int expIrqs(input bit transp, input bit hold, input bit fe);
    return transp ? int'(hold) : int'(hold && !fe);
  endfunction

  task automatic clearMem();
    for (int i = 0; i < 256; i++) mem[i] = '0;
  endtask

  task automatic mkDesc(input int a, input bit hold, input bit fe, input int len,
                        input int dptr, input int nxt);
    mem[a]   = {hold, fe, 14'd0, 16'(len)};
    mem[a+1] = 32'(dptr);
    mem[a+2] = 32'(nxt);
    for (int i = 0; i < len; i++) mem[dptr+i] = $urandom;
  endtask

  task automatic doReset(input bit mode);
    @(negedge clk);
    rstN = 1'b0; start = 1'b0; bufReq = 1'b0; holdResetCmd = 1'b0;
    modeTransparent = mode;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic go(input int a);
    @(negedge clk); start = 1'b1; startAddr = 16'(a);
    @(negedge clk); start = 1'b0;
  endtask

  task automatic req(input int n);
    @(negedge clk); bufReq = 1'b1; bufReqCnt = 4'(n);
    @(negedge clk); bufReq = 1'b0;
  endtask

  task automatic holdReset();
    @(negedge clk); holdResetCmd = 1'b1;
    @(negedge clk); holdResetCmd = 1'b0;
  endtask

  task automatic chkWords(input string tag, input int base, input int dptr, input int len);
    int bad = 0;
    for (int i = 0; i < len; i++)
      if (wData[base+i] != mem[dptr+i] || wLast[base+i] != (i == len-1)) bad++;
    chkEq(tag, bad, 0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 256; i++) mem[i] = '0;
  end

  initial begin
    int w0, i0, m0, m1, w1, l0, l1, ab;
    // ---------- framed chain, reset state ----------
    doReset(1'b0);
    clearMem();
    w0 = wN; i0 = iN; m0 = mN;
    repeat (6) @(negedge clk);
    chkEq("R1 no memory read before start", mN - m0, 0);
    chkEq("R1 no buffer write before start", wN - w0, 0);
    chkEq("R1 no interrupt before start", iN - i0, 0);
    l0 = 2 + $urandom % 5;
    l1 = 2 + $urandom % 5;
    mkDesc(16, 1'b0, 1'b1, l0, 64, 20);
    mkDesc(20, 1'b1, 1'b1, l1, 96, 24);
    go(16);
    req(l0);
    req(l1);
    repeat (200) @(negedge clk);
    chkEq("R2 first fetch at flags word", mAddr[m0], 16);
    chkEq("R2 second fetch at data pointer", mAddr[m0+1], 17);
    chkEq("R2 third fetch at next pointer", mAddr[m0+2], 18);
    chkEq("R2 word count over two descriptors", wN - w0, l0 + l1);
    chkWords("R2 first section data and last mark", w0, 64, l0);
    chkWords("R2 second section data and last mark", w0 + l0, 96, l1);
    chkEq("R5 no interrupt for framed hold with frame end", iN - i0, expIrqs(1'b0, 1'b1, 1'b1));
    ab = 0;
    for (int i = w0; i < wN; i++) ab += int'(wAbort[i]);
    chkEq("R3 no abort when frame end set", ab, 0);
    m1 = mN; w1 = wN;
    req(3);
    repeat (60) @(negedge clk);
    chkEq("R7 suspended channel makes no reads", mN - m1, 0);
    chkEq("R7 suspended channel makes no writes", wN - w1, 0);

    // ---------- framed hold without frame end ----------
    doReset(1'b0);
    clearMem();
    mkDesc(32, 1'b1, 1'b0, 3, 128, 36);
    mkDesc(36, 1'b1, 1'b1, 4, 144, 40);
    w0 = wN; i0 = iN;
    go(32);
    req(3);
    repeat (80) @(negedge clk);
    chkEq("R3 whole section delivered", wN - w0, 3);
    chkWords("R3 section data", w0, 128, 3);
    chkEq("R3 abort on last word", wAbort[w0+2], 1);
    chkEq("R3 no abort before last word", int'(wAbort[w0]) + int'(wAbort[w0+1]), 0);
    chkEq("R3 one interrupt", iN - i0, expIrqs(1'b0, 1'b1, 1'b0));
    chkEq("R13 interrupt code", iCode[i0], 4'hA);
    chkEq("R13 interrupt channel", iChan[i0], 5);
    chkEq("R3 interrupt two cycles after last word", iCyc[i0] - wCyc[w0+2], 2);
    req(5);
    repeat (40) @(negedge clk);
    chkEq("R7 requests not served while suspended", wN - w0, 3);
    holdReset();
    repeat (60) @(negedge clk);
    chkEq("R10 hold still set keeps channel parked", wN - w0, 3);
    chkEq("R10 no extra interrupt", iN - i0, 1);
    mem[32][31] = 1'b0;
    holdReset();
    repeat (120) @(negedge clk);
    chkEq("R9 resume moves to next descriptor", wN - w0, 7);
    chkWords("R8 stored requests served after resume", w0 + 3, 144, 4);
    chkEq("R5 framed hold with frame end gives no interrupt", iN - i0, 1);

    // ---------- transparent mode ----------
    doReset(1'b1);
    clearMem();
    mkDesc(48, 1'b1, 1'b0, 3, 160, 52);
    mkDesc(52, 1'b0, 1'b1, 2, 168, 56);
    mkDesc(56, 1'b1, 1'b1, 2, 176, 60);
    w0 = wN; i0 = iN;
    go(48);
    req(1);
    repeat (40) @(negedge clk);
    chkEq("R12 delivery stops when credit is used", wN - w0, 1);
    mem[48][31] = 1'b0;
    holdReset();
    repeat (10) @(negedge clk);
    chkEq("R11 hold reset while active changes nothing", wN - w0, 1);
    req(6);
    repeat (200) @(negedge clk);
    chkEq("R6 walk continues after cleared hold", wN - w0, 7);
    chkWords("R6 first section", w0, 160, 3);
    chkWords("R6 second section", w0 + 3, 168, 2);
    chkWords("R6 third section", w0 + 5, 176, 2);
    ab = 0;
    for (int i = w0; i < wN; i++) ab += int'(wAbort[i]);
    chkEq("R4 no abort in transparent mode", ab, 0);
    chkEq("R4 one interrupt per hold descriptor",
          iN - i0, expIrqs(1'b1, 1'b1, 1'b0) + expIrqs(1'b1, 1'b0, 1'b1) + expIrqs(1'b1, 1'b1, 1'b1));
    chkEq("R4 interrupt codes", int'(iCode[i0] == 4'hA) + int'(iCode[i0+1] == 4'hA), 2);

    // ---------- open-request saturation ----------
    doReset(1'b0);
    clearMem();
    mkDesc(0, 1'b1, 1'b1, 0, 16, 4);
    mkDesc(4, 1'b1, 1'b1, 70, 128, 8);
    w0 = wN; i0 = iN;
    go(0);
    repeat (30) @(negedge clk);
    for (int k = 0; k < 10; k++) req(15);
    repeat (20) @(negedge clk);
    chkEq("R7 no data from empty held descriptor", wN - w0, 0);
    mem[0][31] = 1'b0;
    holdReset();
    repeat (700) @(negedge clk);
    chkEq("R8 served count equals saturated total", wN - w0, satCredit(150, 63));
    req(7);
    repeat (100) @(negedge clk);
    chkEq("R8 remaining words after new request", wN - w0, 70);
    chkWords("R8 long section data", w0, 128, 70);
    chkEq("R5 no interrupt in saturation run", iN - i0, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", nChecks, nErr);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      nErr++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", nChecks, nErr);
      $finish;
    end
  end
endmodule